// File: doc/BRIEF.md
# DRAM Row Refresh Controller

This controller sits between a host and a dynamic memory array. A dynamic cell loses its charge within a retention window, so every row must be refreshed within that window. Refreshing word by word would take a large share of the array's access slots. The controller therefore refreshes one whole row at a time. An interval timer spaces the row refreshes evenly. The spacing is the retention time divided by the number of rows, expressed in clock cycles. A row counter steps through the rows in turn and wraps back to the first row after the last.

Host traffic uses a valid/ready handshake. When a refresh is due and no host access is in flight, the controller takes the array for one cycle and holds ready low during that cycle. A read destroys the cell that is read. The controller therefore keeps the word it read and writes it back to the same address in the next cycle. That write-back cycle is also when the data is returned to the host. A sticky error flag is raised if a second refresh falls due while an earlier one has still not been served.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While reset is held and right after it is released: ready is high, overrun is low, no refresh is issued, and the refresh row is 0.
- R2: A refresh becomes due every INTERVAL cycles. The first one is due in cycle INTERVAL-1 after reset is released, and it is served one cycle later if the host is idle.
- R3: A refresh cycle lasts exactly one cycle. In that cycle arr_ref is high, ready is low and arr_en is low.
- R4: arr_ref_row shows the row counter, which starts at 0. The counter advances by one after each refresh and wraps from ROWS-1 to 0.
- R5: An accepted read (host_we=0) drives arr_en=1 and arr_we=0 at host_addr in the same cycle. In the next cycle the controller writes the captured word back to the same address with arr_we=1. host_rvalid is high in that write-back cycle, and host_rdata carries the word.
- R6: ready is low during a write-back cycle. A refresh that falls due during a write-back waits until the write-back has finished.
- R7: An accepted write (host_we=1) is a single array cycle with arr_we=1, host_addr and host_wdata, and it is followed by no write-back.
- R8: If a refresh falls due while another refresh is still pending and unserved, overrun goes high in the next cycle and stays high until reset.
- R9: INTERVAL is RETENTION_NS / (ROWS * CLK_NS), rounded down, with a minimum of 1.
- R10: host_valid while ready is low is ignored: it causes no array access.
- R11: Data written through the controller reads back unchanged after any number of reads, because every read is restored by its write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_valid | input | 1 | Host requests an access |
| host_ready | output | 1 | Controller accepts the request this cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W (10) | Word address as {row, column} |
| host_wdata | input | DATA_W (4) | Write data |
| host_rvalid | output | 1 | Read data valid (write-back cycle) |
| host_rdata | output | DATA_W (4) | Read data |
| arr_en | output | 1 | Array access strobe |
| arr_we | output | 1 | Array write when arr_en is high |
| arr_addr | output | ADDR_W (10) | Array word address |
| arr_wdata | output | DATA_W (4) | Array write data |
| arr_rdata | input | DATA_W (4) | Array read data, valid in the same cycle as the read |
| arr_ref | output | 1 | Row refresh strobe |
| arr_ref_row | output | ROW_W (6) | Row being refreshed |
| overrun | output | 1 | Sticky missed-refresh flag |

## Verification
The first stimulus pattern leaves the host idle for more than a full row sweep. This separates the timer period, the first-refresh cycle and the row wrap from any arbitration effect. Back-to-back writes followed by two full rounds of reads then collide with refreshes at many phases of the interval. The second round of reads only returns the written data if every write-back restored its cell. A mixed read/write pattern with gaps in host_valid keeps valid high during refresh and write-back cycles, which shows that stalled requests are ignored. A second instance with a one-cycle interval, given a read right at reset release, forces the missed-refresh flag and shows that it is sticky.

// File: rtl/dref_pkg.sv
package dref_pkg;

  typedef enum logic [0:0] {
    ARB_IDLE = 1'b0,
    ARB_WB   = 1'b1
  } arb_state_e;

  // Cycles between row refreshes: retention spread evenly over the rows.
  function automatic int refresh_interval(input int ret_ns, input int rows, input int clk_ns);
    int v;
    v = ret_ns / (rows * clk_ns);
    return (v < 1) ? 1 : v;
  endfunction

  // Bits needed to index n items, never less than one.
  function automatic int index_width(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/dref_tracker.sv
module dref_tracker #(
  parameter int INTERVAL = 3125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic svc,
  output logic expire,
  output logic pend,
  output logic overrun
);
  import dref_pkg::*;

  localparam int CNT_W = index_width(INTERVAL);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;
  logic             ovr_q;

  assign expire  = (cnt_q == '0);
  assign pend    = pend_q;
  assign overrun = ovr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= LAST;
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      cnt_q  <= expire ? LAST : cnt_q - 1'b1;
      pend_q <= expire | (pend_q & ~svc);
      ovr_q  <= ovr_q | (expire & pend_q & ~svc);
    end
  end

  assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !expire |=> (cnt_q == $past(cnt_q) - 1'b1));
  assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt_q == LAST));
  assert_pend_after_expire_R2: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pend);
  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  assert_overrun_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(expire && pend && !svc));

endmodule

// File: rtl/dref_row_counter.sv
module dref_row_counter #(
  parameter int ROWS  = 64,
  parameter int ROW_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [ROW_W-1:0] row
);
  localparam logic [ROW_W-1:0] TOP = ROW_W'(ROWS - 1);

  logic [ROW_W-1:0] row_q;
  assign row = row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    row_q <= '0;
    else if (step) row_q <= (row_q == TOP) ? '0 : row_q + 1'b1;
  end

  assert_row_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (row_q == (($past(row_q) == TOP) ? '0 : $past(row_q) + 1'b1)));
  assert_row_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(row_q));
  assert_row_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    row_q <= TOP);

endmodule

// File: rtl/dref_arbiter.sv
module dref_arbiter #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pend,
  output logic              svc,
  output logic              in_wb,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_rvalid,
  output logic [DATA_W-1:0] host_rdata,
  output logic              arr_en,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  input  logic [DATA_W-1:0] arr_rdata
);
  import dref_pkg::*;

  arb_state_e        state_q;
  logic [DATA_W-1:0] rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic              accept;
  logic              idle;

  assign idle        = (state_q == ARB_IDLE);
  assign in_wb       = (state_q == ARB_WB);
  assign svc         = idle & pend;
  assign host_ready  = idle & ~pend;
  assign accept      = host_valid & host_ready;

  assign arr_en      = accept | in_wb;
  assign arr_we      = in_wb | (accept & host_we);
  assign arr_addr    = in_wb ? addr_q : host_addr;
  assign arr_wdata   = in_wb ? rd_q : host_wdata;
  assign host_rvalid = in_wb;
  assign host_rdata  = rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
      rd_q    <= '0;
      addr_q  <= '0;
    end else if (accept && !host_we) begin
      state_q <= ARB_WB;
      rd_q    <= arr_rdata;
      addr_q  <= host_addr;
    end else begin
      state_q <= ARB_IDLE;
    end
  end

  assert_wb_follows_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_ready && !host_we) |=>
      (arr_en && arr_we && arr_addr == $past(host_addr) && arr_wdata == $past(arr_rdata)));
  assert_no_wb_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_ready && host_we) |=> !host_rvalid);
  assert_ready_low_in_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |-> !host_ready);
  assert_ref_excludes_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(svc && arr_en));
  assert_stall_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_ready && !host_rvalid) |-> !arr_en);

endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
  parameter int ROWS         = 64,
  parameter int COL_W        = 4,
  parameter int DATA_W       = 4,
  parameter int CLK_NS       = 20,
  parameter int RETENTION_NS = 4000000,
  parameter int ROW_W        = dref_pkg::index_width(ROWS),
  parameter int ADDR_W       = ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_rvalid,
  output logic [DATA_W-1:0] host_rdata,
  output logic              arr_en,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic              arr_ref,
  output logic [ROW_W-1:0]  arr_ref_row,
  output logic              overrun
);
  import dref_pkg::*;

  localparam int INTERVAL = refresh_interval(RETENTION_NS, ROWS, CLK_NS);

  logic svc;
  logic pend;
  logic expire;
  logic in_wb;

  dref_tracker #(.INTERVAL(INTERVAL)) u_tracker (
    .clk(clk), .rst_n(rst_n), .svc(svc),
    .expire(expire), .pend(pend), .overrun(overrun)
  );

  dref_row_counter #(.ROWS(ROWS), .ROW_W(ROW_W)) u_rows (
    .clk(clk), .rst_n(rst_n), .step(svc), .row(arr_ref_row)
  );

  dref_arbiter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .pend(pend), .svc(svc), .in_wb(in_wb),
    .host_valid(host_valid), .host_ready(host_ready), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rvalid(host_rvalid), .host_rdata(host_rdata),
    .arr_en(arr_en), .arr_we(arr_we), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .arr_rdata(arr_rdata)
  );

  assign arr_ref = svc;

  initial assert_interval_floor_R9: assert (INTERVAL >= 1);

  assert_refresh_waits_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_wb |-> !arr_ref);
  assert_refresh_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_ref && !expire) |=> !arr_ref);
  assert_ready_low_on_ref_R3: assert property (@(posedge clk) disable iff (!rst_n)
    arr_ref |-> !host_ready);

endmodule

// File: tb/test_dram_refresh_ctrl.sv
module test_dram_refresh_ctrl;
  localparam int ROWS   = 8;
  localparam int COL_W  = 2;
  localparam int DATA_W = 4;
  localparam int CLK_NS = 20;
  localparam int RET_NS = 1920;
  localparam int IV     = 12;          // 1920 / (8 * 20), per R9
  localparam int ROW_W  = 3;
  localparam int AW     = ROW_W + COL_W;
  localparam int WORDS  = 1 << AW;
  localparam int NOPS   = 160;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              hv = 1'b0, hwe = 1'b0;
  logic [AW-1:0]     haddr = '0;
  logic [DATA_W-1:0] hwd = '0;
  logic              host_ready, host_rvalid, arr_en, arr_we, arr_ref, overrun;
  logic [DATA_W-1:0] host_rdata, arr_wdata, arr_rdata;
  logic [AW-1:0]     arr_addr;
  logic [ROW_W-1:0]  arr_ref_row;

  dram_refresh_ctrl #(.ROWS(ROWS), .COL_W(COL_W), .DATA_W(DATA_W),
                      .CLK_NS(CLK_NS), .RETENTION_NS(RET_NS)) i_dram_refresh_ctrl (
    .clk(clk), .rst_n(rst_n), .host_valid(hv), .host_ready(host_ready),
    .host_we(hwe), .host_addr(haddr), .host_wdata(hwd),
    .host_rvalid(host_rvalid), .host_rdata(host_rdata),
    .arr_en(arr_en), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .arr_rdata(arr_rdata), .arr_ref(arr_ref), .arr_ref_row(arr_ref_row), .overrun(overrun)
  );

  // Second instance: one-cycle interval, read held from release (R8).
  logic              o_ready, o_rvalid, o_en, o_we, o_ref, o_ovr;
  logic [DATA_W-1:0] o_rdata, o_wdata;
  logic [AW-1:0]     o_addr;
  logic [ROW_W-1:0]  o_row;

  dram_refresh_ctrl #(.ROWS(ROWS), .COL_W(COL_W), .DATA_W(DATA_W),
                      .CLK_NS(CLK_NS), .RETENTION_NS(ROWS * CLK_NS)) i_dram_refresh_ctrl_ovr (
    .clk(clk), .rst_n(rst_n), .host_valid(1'b1), .host_ready(o_ready),
    .host_we(1'b0), .host_addr('0), .host_wdata('0),
    .host_rvalid(o_rvalid), .host_rdata(o_rdata),
    .arr_en(o_en), .arr_we(o_we), .arr_addr(o_addr), .arr_wdata(o_wdata),
    .arr_rdata('0), .arr_ref(o_ref), .arr_ref_row(o_row), .overrun(o_ovr)
  );

  // Array model: a read clears the cell, a write stores.
  logic [DATA_W-1:0] mem [WORDS];
  assign arr_rdata = mem[arr_addr];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (arr_en) begin
      mem[arr_addr] <= arr_we ? arr_wdata : '0;
    end
  end

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic op_of(input int i, output bit we, output int a, output int d);
    if (i < 32)      begin we = 1; a = i;             d = (i * 3 + 5) % 16; end
    else if (i < 96) begin we = 0; a = i % 32;        d = 0; end
    else             begin we = i[0]; a = (i * 5) % 32; d = i % 16; end
  endtask

  initial begin
    int shadow [WORDS];
    int owed, row, m_rd, m_addr, first_ref, opi, k;
    bit m_wb, m_ovr;
    owed = 0; row = 0; m_rd = 0; m_addr = 0; m_wb = 0; m_ovr = 0;
    first_ref = -1; opi = 0; k = 0;
    for (int i = 0; i < WORDS; i++) shadow[i] = 0;

    repeat (3) @(negedge clk);
    chk("R1", "ready in reset", host_ready, 1);
    chk("R1", "overrun in reset", overrun, 0);
    chk("R1", "arr_ref in reset", arr_ref, 0);
    chk("R1", "ref row in reset", arr_ref_row, 0);
    rst_n = 1'b1;

    while (k < 3000 && !(opi >= NOPS && k > 700)) begin
      bit exp_svc, exp_ready, accept, expire, we;
      int a, d;
      if (k > 0) @(negedge clk);
      if (k >= 110 && opi < NOPS && !(opi >= 96 && k % 3 == 0)) begin
        op_of(opi, we, a, d);
        hv = 1'b1; hwe = we; haddr = AW'(a); hwd = DATA_W'(d);
      end else begin
        hv = (k % 7 == 3);      // stray valid when ops are idle
        hwe = 1'b0; haddr = AW'(k % 32); hwd = '0;
        if (k < 110) hv = 1'b0;
      end
      #1;
      exp_svc   = !m_wb && owed > 0;
      exp_ready = !m_wb && owed == 0;
      accept    = hv && exp_ready;
      if (k == 0) begin
        chk("R1", "ready after release", host_ready, 1);
        chk("R1", "overrun after release", overrun, 0);
      end
      chk("R3", "arr_ref", arr_ref, exp_svc);
      if (exp_svc) chk("R4", "refresh row", arr_ref_row, row);
      if (arr_ref && first_ref < 0) begin
        first_ref = k;
        chk("R2", "first refresh cycle (R9 interval)", k, IV);
      end
      chk("R6", "host_ready", host_ready, exp_ready);
      chk("R10", "arr_en", arr_en, accept || m_wb);
      if (accept || m_wb) begin
        chk("R7", "arr_we", arr_we, m_wb || hwe);
        chk("R5", "arr_addr", arr_addr, m_wb ? m_addr : int'(haddr));
        if (m_wb || hwe) chk("R5", "arr_wdata", arr_wdata, m_wb ? m_rd : int'(hwd));
      end
      chk("R5", "host_rvalid", host_rvalid, m_wb);
      if (m_wb) chk("R11", "host_rdata", host_rdata, m_rd);
      chk("R8", "overrun", overrun, m_ovr);

      // Reference update for the coming edge.
      expire = (k % IV) == (IV - 1);
      if (expire && owed > 0 && !exp_svc) m_ovr = 1'b1;
      if (exp_svc) begin owed--; row = (row + 1) % ROWS; end
      if (expire) owed = 1;
      m_wb = accept && !hwe;
      if (accept && !hwe) begin m_rd = shadow[haddr]; m_addr = int'(haddr); end
      if (accept && hwe) shadow[haddr] = int'(hwd);
      if (accept && k >= 110 && opi < NOPS) opi++;
      k++;
    end
    chk("R11", "all operations accepted", opi, NOPS);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  // Overrun instance checks, aligned with release at the same negedge.
  initial begin
    @(posedge rst_n);
    #1;
    chk("R8", "ovr inst ready cycle 0", o_ready, 1);
    chk("R8", "ovr inst overrun cycle 0", o_ovr, 0);
    @(negedge clk); #1;
    chk("R8", "ovr inst write-back cycle 1", o_rvalid, 1);
    chk("R8", "ovr inst overrun cycle 1", o_ovr, 0);
    @(negedge clk); #1;
    chk("R8", "ovr inst overrun cycle 2", o_ovr, 1);
    repeat (8) @(negedge clk);
    #1;
    chk("R8", "ovr inst overrun sticky", o_ovr, 1);
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule